// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block collects up to 64 interrupt source lines, split into two banks of 32, and folds them into one request line toward the processor. Every bank has four word registers. The **event** register latches rising edges. The **enable** register holds a mask that software writes and can read back. A write to the **ack** register clears latched events. The **level** register shows the raw source lines as they are now. A fixed mask in each bank marks some bits as level-triggered. Those bits never latch an event and are judged live from the source line.

A source counts as pending when it is enabled and either holds a latched event or is a level-type line that is high. The request output is high while any source in either bank is pending. A read-only identifier register reports the highest-numbered pending source, so a handler can find its work in one read. A second, downstream controller can feed its request into one level-type bit of the first bank. From there it behaves as an ordinary source.

Enabling a source whose line is already high does not, by itself, produce a request. Only a new rising edge latches an event.

Top module: `banked_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, every enable bit and every event bit is 0, `irq_o` is 0, and the identifier register at word 15 reads 0xFF.
- R2: A 0-to-1 transition of an edge-type source sets its event bit on the next clock edge, whether or not the source is enabled. Bank 0 (sources 0–31) has its event register at word 8. Bank 1 (sources 32–63, bit n-32) has its event register at word 4.
- R3: A write to the ack register clears each event bit where the written data holds a 1 and leaves every other bit unchanged. The ack register is at word 10 for bank 0 and word 6 for bank 1.
- R4: When an ack write and a new rising edge of the same source meet on one clock edge, the event bit ends set.
- R5: The level-type sources of bank 0 are bits 20–28 (mask 0x1FF00000), and their event bits are never set. Bank 1 has no level-type bits, so all of its sources latch.
- R6: The enable register (word 9 for bank 0, word 5 for bank 1) reads back the last value written. `irq_o` is high exactly when, in some bank, (event OR (source AND level mask)) AND enable is non-zero.
- R7: Setting an enable bit while that edge-type source is already high, with its event clear, leaves the event bit at 0 and `irq_o` at 0.
- R8: `cascade_i` is ORed into bank 0 source bit 24, a level-type bit. It appears in the level register and raises `irq_o` when bit 24 is enabled.
- R9: Word 15 reads the index (0–63) of the highest-numbered pending source, or 0xFF when nothing is pending.
- R10: Reads have no side effects. The level register (word 11 for bank 0, word 7 for bank 1) returns the raw source lines. The ack register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Interrupt source lines, synchronous to `clk` |
| cascade_i | input | 1 | Request from a downstream controller |
| addr_i | input | 4 | Word address (byte address bits 5:2) |
| wdata_i | input | 32 | Write data |
| wen_i | input | 1 | Write strobe, single cycle |
| ren_i | input | 1 | Read strobe; `rdata_o` is valid in the same cycle |
| rdata_o | output | 32 | Read data, 0 when `ren_i` is low |
| irq_o | output | 1 | Request to the processor |

## Verification
Two things can land on the same event bit on one clock edge: an acknowledge write that clears the bit, and a fresh rising edge of its source that sets it. The bench provokes this in three steps. It first latches an edge and lets the line fall. It then raises the line in the same cycle that it writes a 1 to that bit of the ack register, and expects the event bit to read back as 1. As a control, a plain ack with no edge must clear the bit.

// File: rtl/irq_pkg.sv
// Package: irq_pkg
// Shared constants for the two-bank interrupt controller: bank geometry,
// register word indices and the "nothing pending" identifier code.
package irq_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int ID_W      = 8;

    localparam logic [ID_W-1:0] ID_NONE = 8'hFF;

    // Register offsets inside a bank, in words.
    localparam logic [1:0] OFS_EVENT  = 2'd0;
    localparam logic [1:0] OFS_ENABLE = 2'd1;
    localparam logic [1:0] OFS_ACK    = 2'd2;
    localparam logic [1:0] OFS_LEVEL  = 2'd3;

    localparam logic [3:0] WORD_ID = 4'd15;

    // Base word of each bank: the low bank sits above the high bank.
    function automatic logic [3:0] bank_base(input int b);
        return (b == 0) ? 4'd8 : 4'd4;
    endfunction
endpackage

// File: rtl/irq_bank.sv
// Module: irq_bank
// One bank of sources. It holds the edge detector, the event latch, the
// enable register and the pending reduction. Level-type bits (LVL_MASK)
// bypass the event latch. Assumes src is already synchronous to clk.
module irq_bank #(
    parameter int          W        = 32,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] event_q,
    output logic [W-1:0] enable_q,
    output logic [W-1:0] pending
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;

    // Rising edges of edge-type sources only.
    always_comb rise = src & ~prev_q & ~LVL_MASK;

    // Previous-sample, event latch and enable registers; a new edge beats ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= src;
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            prev_q   <= src;
            event_q  <= (ack_we ? (event_q & ~wdata) : event_q) | rise;
            if (en_we) enable_q <= wdata;
        end
    end

    // Pending set: latched edges or live level lines, gated by enable.
    always_comb pending = (event_q | (src & LVL_MASK)) & enable_q;
endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Returns the index of the highest set bit of a vector, or NONE when the
// vector is zero. Purely combinational.
module irq_prio_enc #(
    parameter int            N     = 64,
    parameter int            OUT_W = 8,
    parameter logic [OUT_W-1:0] NONE = '1
) (
    input  logic [N-1:0]     req,
    output logic [OUT_W-1:0] idx
);
    // Scan upward so the highest set bit is the last one assigned.
    always_comb begin
        idx = NONE;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = OUT_W'(i);
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
// Module: banked_irq_ctrl
// Top of the interrupt controller. It decodes the word address into per-bank
// strobes, builds the bank source vectors (with the cascade input folded into
// one bit of bank 0), muxes read data and drives the request output.
// Assumes single-cycle strobes and synchronous source lines.
module banked_irq_ctrl #(
    parameter logic [31:0] LVL_MASK0   = 32'h1FF0_0000,
    parameter logic [31:0] LVL_MASK1   = 32'h0000_0000,
    parameter int          CASCADE_BIT = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] src_i,
    input  logic        cascade_i,
    input  logic [3:0]  addr_i,
    input  logic [31:0] wdata_i,
    input  logic        wen_i,
    input  logic        ren_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    import irq_pkg::*;

    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_src;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_ev;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_en;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_pend;
    logic [NUM_SRC-1:0]               pend_all;
    logic [ID_W-1:0]                  top_id;

    // Source vectors: the cascade request joins one bit of bank 0.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            bank_src[b] = src_i[b*BANK_W +: BANK_W];
        bank_src[0][CASCADE_BIT] = src_i[CASCADE_BIT] | cascade_i;
    end

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            localparam logic [3:0]  BASE = bank_base(gb);
            localparam logic [31:0] LVL  = (gb == 0) ? LVL_MASK0 : LVL_MASK1;
            logic en_we;
            logic ack_we;

            // Write strobes for this bank's enable and ack words.
            always_comb begin
                en_we  = wen_i && (addr_i == (BASE | {2'b00, OFS_ENABLE}));
                ack_we = wen_i && (addr_i == (BASE | {2'b00, OFS_ACK}));
            end

            irq_bank #(.W(BANK_W), .LVL_MASK(LVL)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .src      (bank_src[gb]),
                .en_we    (en_we),
                .ack_we   (ack_we),
                .wdata    (wdata_i),
                .event_q  (bank_ev[gb]),
                .enable_q (bank_en[gb]),
                .pending  (bank_pend[gb])
            );

            assign pend_all[gb*BANK_W +: BANK_W] = bank_pend[gb];
        end
    endgenerate

    irq_prio_enc #(.N(NUM_SRC), .OUT_W(ID_W), .NONE(ID_NONE)) u_prio (
        .req (pend_all),
        .idx (top_id)
    );

    // Request output: any pending source in any bank.
    always_comb irq_o = |pend_all;

    // Read mux: bank registers by base and offset, plus the identifier word.
    always_comb begin
        rdata_o = '0;
        if (ren_i) begin
            if (addr_i == WORD_ID) begin
                rdata_o = {{(32-ID_W){1'b0}}, top_id};
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (addr_i[3:2] == bank_base(b)[3:2]) begin
                        case (addr_i[1:0])
                            OFS_EVENT:  rdata_o = bank_ev[b];
                            OFS_ENABLE: rdata_o = bank_en[b];
                            OFS_LEVEL:  rdata_o = bank_src[b];
                            default:    rdata_o = '0;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: irq_ctrl_chk
// Property checker for banked_irq_ctrl, attached by bind. It watches the
// bank-0 source lines, event/enable state, the write port and the outputs.
module irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] src0,
    input logic [31:0] ev0,
    input logic [31:0] ev1,
    input logic [31:0] en0,
    input logic [31:0] en1,
    input logic [3:0]  addr_i,
    input logic [31:0] wdata_i,
    input logic        wen_i,
    input logic        irq_o,
    input logic [7:0]  top_id
);
    localparam logic [31:0] LVL0 = 32'h1FF0_0000;

    logic        rst_q;
    logic [31:0] src0_q;
    logic [31:0] edge0;

    // Delayed reset and source samples for edge tracking.
    always_ff @(posedge clk) begin
        rst_q  <= rst_n;
        src0_q <= src0;
    end

    always_comb edge0 = src0 & ~src0_q & ~LVL0;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q == 1'b0) |-> (en0 == 0 && en1 == 0 && ev0 == 0 && ev1 == 0 && !irq_o));

    // R5
    level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev0 & LVL0) == 32'h0);

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && addr_i == 4'd10) |=> ((ev0 & $past(wdata_i) & ~$past(edge0)) == 32'h0));

    // R4
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge0 != 32'h0) |=> ((ev0 & $past(edge0)) == $past(edge0)));

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en0 | en1) != 32'h0));

    // R9
    id_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (top_id != 8'hFF));
endmodule

bind banked_irq_ctrl irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src0    (bank_src[0]),
    .ev0     (bank_ev[0]),
    .ev1     (bank_ev[1]),
    .en0     (bank_en[0]),
    .en1     (bank_en[1]),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wen_i   (wen_i),
    .irq_o   (irq_o),
    .top_id  (top_id)
);

// File: tb/banked_irq_ctrl_tb.sv
// Directed bench for banked_irq_ctrl: one task per scenario.
module banked_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src_i;
    logic        cascade_i;
    logic [3:0]  addr_i;
    logic [31:0] wdata_i;
    logic        wen_i;
    logic        ren_i;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [3:0] EV0 = 4'd8, EN0 = 4'd9, ACK0 = 4'd10, LV0 = 4'd11;
    localparam logic [3:0] EV1 = 4'd4, EN1 = 4'd5, ACK1 = 4'd6, LV1 = 4'd7;
    localparam logic [3:0] IDW = 4'd15;

    always #5 clk = ~clk;

    banked_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .cascade_i(cascade_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .wen_i(wen_i), .ren_i(ren_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wen_i = 1'b1;
        @(negedge clk);
        wen_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; ren_i = 1'b1;
        #1 d = rdata_o;
        ren_i = 1'b0;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, {31'b0, irq_o}, {31'b0, exp});
    endtask

    task automatic clean();
        cascade_i = 1'b0;
        set_src(64'h0);
        wr(EN0, 32'h0); wr(EN1, 32'h0);
        wr(ACK0, 32'hFFFF_FFFF); wr(ACK1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(EN0, v); check("R1 enable0 after reset", v, 32'h0);
        rd(EN1, v); check("R1 enable1 after reset", v, 32'h0);
        rd(EV0, v); check("R1 event0 after reset", v, 32'h0);
        rd(IDW, v); check("R1 id after reset", v, 32'hFF);
        check_irq("R1 irq after reset", 1'b0);
    endtask

    task automatic t_edge_enable_ack();
        logic [31:0] v;
        clean();
        set_src(64'h0000_0100_0000_0008);   // bit 3 and bit 40
        rd(EV0, v); check("R2 bank0 edge latched while disabled", v, 32'h8);
        rd(EV1, v); check("R2 bank1 edge latched", v, 32'h100);
        check_irq("R6 no irq while disabled", 1'b0);
        wr(EN0, 32'h8);
        rd(EN0, v); check("R6 enable0 readback", v, 32'h8);
        check_irq("R6 irq when enabled event", 1'b1);
        rd(IDW, v); check("R9 id single pending", v, 32'd3);
        wr(EN1, 32'h100);
        rd(IDW, v); check("R9 id highest of two", v, 32'd40);
        wr(ACK0, 32'h0);
        rd(EV0, v); check("R3 ack zero no effect", v, 32'h8);
        wr(ACK0, 32'h8);
        rd(EV0, v); check("R3 ack clears bit", v, 32'h0);
        wr(ACK1, 32'h100);
        check_irq("R3 irq drops after acks", 1'b0);
        rd(IDW, v); check("R9 id none", v, 32'hFF);
    endtask

    task automatic t_enable_asserted();
        logic [31:0] v;
        // Source bit 3 is still high from the previous scenario.
        wr(EN0, 32'h0);
        wr(EN0, 32'h8);
        rd(EV0, v); check("R7 no event on enable of high line", v, 32'h0);
        check_irq("R7 no irq on enable of high line", 1'b0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        clean();
        set_src(64'h0040_0000_0040_0000);   // bank0 bit 22, bank1 bit 22
        rd(EV0, v); check("R5 level bit not latched", v, 32'h0);
        rd(EV1, v); check("R5 bank1 bit22 latched as edge", v, 32'h0040_0000);
        rd(LV0, v); check("R10 level reg raw lines", v, 32'h0040_0000);
        wr(EN0, 32'h0040_0000);
        check_irq("R5 level irq live", 1'b1);
        set_src(64'h0040_0000_0000_0000);
        check_irq("R5 level irq follows line", 1'b0);
        rd(LV1, v); check("R10 bank1 level reg", v, 32'h0040_0000);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        clean();
        wr(EN0, 32'h0100_0000);
        @(negedge clk); cascade_i = 1'b1;
        check_irq("R8 cascade raises irq", 1'b1);
        rd(LV0, v); check("R8 cascade in level reg", v, 32'h0100_0000);
        rd(IDW, v); check("R8 cascade id", v, 32'd24);
        rd(EV0, v); check("R8 cascade not latched", v, 32'h0);
        @(negedge clk); cascade_i = 1'b0;
        check_irq("R8 cascade release", 1'b0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        clean();
        set_src(64'h20);
        set_src(64'h0);
        rd(EV0, v); check("R2 event held after line falls", v, 32'h20);
        // New edge and ack of the same bit on one clock edge.
        @(negedge clk);
        src_i = 64'h20; addr_i = ACK0; wdata_i = 32'h20; wen_i = 1'b1;
        @(negedge clk);
        wen_i = 1'b0;
        rd(EV0, v); check("R4 edge beats ack", v, 32'h20);
        rd(EV0, v); check("R10 event read has no side effect", v, 32'h20);
        rd(ACK0, v); check("R10 ack reads zero", v, 32'h0);
        wr(ACK0, 32'h20);
        rd(EV0, v); check("R4 control ack alone clears", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_i = '0; cascade_i = 1'b0;
        addr_i = '0; wdata_i = '0; wen_i = 1'b0; ren_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_enable_ack();
        t_enable_asserted();
        t_level();
        t_cascade();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule